// File: doc/BRIEF.md
# Two-Stage Escalating Watchdog Timer

This block is a register-mapped countdown watchdog. A prescaler divides the system clock into fixed ticks, and a 10-bit counter decrements once per tick. Software keeps the system alive by writing the reload register before the count runs out. It can also halt the timer, change the initial value and read how many ticks remain.

Expiry escalates in two steps. The first time the count runs out, the block raises a timeout flag and emits a single-clock event, which is typically routed to an interrupt or management handler. The counter then reloads and keeps running. If it runs out again while the timeout flag is still set, the block raises a second-stage flag and, unless the no-reboot gate is set, drives a sticky reset request to the system reset controller. A boot-failure flag records that a second-stage expiry happened again while the second-stage flag was still set.

Top module: `wdg_two_stage`

## Requirements
- R1: After reset, the registers read as follows: the count reads 0x0032, both status registers read 0x0000, the control register reads 0x0800 (halted), the configuration register reads 0x0002 (no-reboot set) and the initial-value register reads 0x0032. `expire_evt_o` and `reset_req_o` are low.
- R2: A write to the initial-value register (offset 0x12) whose bits 9:0 are 4 or more stores all 16 bits. Bits 15:10 read back exactly as written.
- R3: A write to the initial-value register whose bits 9:0 are 0 to 3 leaves the whole register unchanged.
- R4: Any write to offset 0x00 loads the counter from bits 9:0 of the initial-value register, whatever the write data. A read of offset 0x00 returns the current count in bits 9:0 and zero above. Writing the initial-value register alone does not change the count.
- R5: Bit 11 of the control register (offset 0x08) is the halt bit. While it is 1, the count does not change and the prescaler is held at zero. All 16 control bits read back as written.
- R6: While the timer runs, the count decrements once every TICK_DIV clocks, starting TICK_DIV clocks after the halt bit is cleared. A tick that finds the count at zero is an expiry. That tick reloads the count from the initial value, so expiries recur every (initial+1)·TICK_DIV clocks.
- R7: An expiry while status bit 3 (offset 0x04) is clear sets that bit and drives `expire_evt_o` high for exactly one clock, in the same cycle as the flag.
- R8: An expiry while status bit 3 is set sets bit 1 of the second status register (offset 0x06) and produces no event pulse.
- R9: A second-stage expiry while bit 1 of the configuration register (offset 0x0C, the no-reboot gate, read/write) is 0 raises `reset_req_o`, which stays high until system reset. While the gate is 1, no request is raised.
- R10: A second-stage expiry while second-status bit 1 is already set also sets second-status bit 2 (the boot-failure flag).
- R11: The status bits are write-1-to-clear. Writing 0 to a bit leaves it alone. If a flag is set and cleared in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| reg_we_i | input | 1 | Register write strobe, one clock per write |
| reg_addr_i | input | 5 | Register byte offset |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for `reg_addr_i`, combinational |
| expire_evt_o | output | 1 | One-clock pulse on a first-stage expiry |
| reset_req_o | output | 1 | Sticky reset request after a second-stage expiry |

## Verification
The assertions assume that a register write lasts one clock and that write data is valid whenever the strobe is high. The bench drives every write on a falling edge for exactly one cycle, so every access meets this. The freeze and step properties also assume that TICK_DIV is at least 2, which means two expiries can never fall on consecutive clocks. The bench runs with a divider of 4 and reads registers only between edges, so reads never change state. It times expiries by counting rising edges from the write that clears the halt bit.

// File: rtl/wdg_pkg.sv
`timescale 1ns/1ps
package wdg_pkg;
   localparam int unsigned WDG_ADDR_W = 5;
   localparam int unsigned WDG_REG_W  = 16;

   // register offsets
   localparam logic [WDG_ADDR_W-1:0] OFS_RELOAD = 5'h00;
   localparam logic [WDG_ADDR_W-1:0] OFS_STAT1  = 5'h04;
   localparam logic [WDG_ADDR_W-1:0] OFS_STAT2  = 5'h06;
   localparam logic [WDG_ADDR_W-1:0] OFS_CTRL   = 5'h08;
   localparam logic [WDG_ADDR_W-1:0] OFS_CFG    = 5'h0C;
   localparam logic [WDG_ADDR_W-1:0] OFS_INIT   = 5'h12;

   // bit positions
   localparam int unsigned BIT_TMO      = 3;
   localparam int unsigned BIT_SECOND   = 1;
   localparam int unsigned BIT_BOOT     = 2;
   localparam int unsigned BIT_HALT     = 11;
   localparam int unsigned BIT_NOREBOOT = 1;

   typedef struct packed {
      logic reload;
      logic stat1;
      logic stat2;
      logic ctrl;
      logic cfg;
      logic init;
   } wdg_wsel_t;
endpackage

// File: rtl/wdg_tick_gen.sv
`timescale 1ns/1ps
module wdg_tick_gen #(
   parameter int unsigned TICK_DIV = 4
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic halt_i,
   output logic tick_o
);
   localparam int unsigned PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

   generate
      if (TICK_DIV == 1) begin : g_direct
         assign tick_o = !halt_i;
      end else begin : g_div
         localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);
         logic [PW-1:0] pre_q;

         always_ff @(posedge clk_i) begin
            if (!rst_ni)             pre_q <= '0;
            else if (halt_i)         pre_q <= '0;
            else if (pre_q == LAST)  pre_q <= '0;
            else                     pre_q <= pre_q + 1'b1;
         end

         assign tick_o = !halt_i && (pre_q == LAST);

         AST_PRE_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
            halt_i |=> (pre_q == '0)); // R5
      end
   endgenerate
endmodule

// File: rtl/wdg_countdown.sv
`timescale 1ns/1ps
module wdg_countdown #(
   parameter int unsigned        CNT_W        = 10,
   parameter logic [CNT_W-1:0]   INIT_DEFAULT = 10'h032
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             tick_i,
   input  logic             halt_i,
   input  logic             reload_i,
   input  logic [CNT_W-1:0] init_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             expire_o
);
   logic [CNT_W-1:0] cnt_q;

   assign expire_o = tick_i && !reload_i && (cnt_q == '0);
   assign cnt_o    = cnt_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni)            cnt_q <= INIT_DEFAULT;
      else if (reload_i)      cnt_q <= init_i;
      else if (tick_i) begin
         if (cnt_q == '0)     cnt_q <= init_i;
         else                 cnt_q <= cnt_q - 1'b1;
      end
   end

   AST_HALT_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      halt_i && !reload_i |=> $stable(cnt_q)); // R5
   AST_DEC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_i && !reload_i && (cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R6
   AST_WRAP_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      expire_o |=> (cnt_q == $past(init_i))); // R6
endmodule

// File: rtl/wdg_escalate.sv
`timescale 1ns/1ps
module wdg_escalate (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic expire_i,
   input  logic noreboot_i,
   input  logic clr_tmo_i,
   input  logic clr_second_i,
   input  logic clr_boot_i,
   output logic tmo_o,
   output logic second_o,
   output logic boot_o,
   output logic evt_o,
   output logic rst_req_o
);
   logic tmo_q, second_q, boot_q, evt_q, req_q;
   logic stage2;

   assign stage2 = expire_i && tmo_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         tmo_q    <= 1'b0;
         second_q <= 1'b0;
         boot_q   <= 1'b0;
         evt_q    <= 1'b0;
         req_q    <= 1'b0;
      end else begin
         if (expire_i)                  tmo_q <= 1'b1;
         else if (clr_tmo_i)            tmo_q <= 1'b0;

         if (stage2)                    second_q <= 1'b1;
         else if (clr_second_i)         second_q <= 1'b0;

         if (stage2 && second_q)        boot_q <= 1'b1;
         else if (clr_boot_i)           boot_q <= 1'b0;

         evt_q <= expire_i && !tmo_q;

         if (stage2 && !noreboot_i)     req_q <= 1'b1;
      end
   end

   assign tmo_o     = tmo_q;
   assign second_o  = second_q;
   assign boot_o    = boot_q;
   assign evt_o     = evt_q;
   assign rst_req_o = req_q;

   AST_EVT_ONE_CLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_q |=> !evt_q); // R7
   AST_EVT_WITH_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_q |-> tmo_q); // R7
   AST_SECOND_AFTER_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(second_q) |-> $past(tmo_q)); // R8
   AST_REQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_q |=> req_q); // R9
   AST_NOREBOOT_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      noreboot_i && !req_q |=> !req_q); // R9
   AST_BOOT_NEEDS_SECOND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(boot_q) |-> $past(second_q)); // R10
endmodule

// File: rtl/wdg_two_stage.sv
`timescale 1ns/1ps
module wdg_two_stage
   import wdg_pkg::*;
#(
   parameter int unsigned      TICK_DIV     = 150_000_000,
   parameter int unsigned      ADDR_W       = WDG_ADDR_W,
   parameter int unsigned      REG_W        = WDG_REG_W,
   parameter int unsigned      CNT_W        = 10,
   parameter int unsigned      MIN_INIT     = 4,
   parameter logic [CNT_W-1:0] INIT_DEFAULT = 10'h032
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              reg_we_i,
   input  logic [ADDR_W-1:0] reg_addr_i,
   input  logic [REG_W-1:0]  reg_wdata_i,
   output logic [REG_W-1:0]  reg_rdata_o,
   output logic              expire_evt_o,
   output logic              reset_req_o
);
   localparam int unsigned UPPER_W = REG_W - CNT_W;
   localparam logic [REG_W-1:0] CTRL_RST = REG_W'(1) << BIT_HALT;
   localparam logic [REG_W-1:0] INIT_RST = {{UPPER_W{1'b0}}, INIT_DEFAULT};

   generate
      if (TICK_DIV < 2)            begin : g_chk_div   $error("TICK_DIV must be at least 2"); end
      if (CNT_W >= REG_W)          begin : g_chk_cnt   $error("CNT_W must be narrower than REG_W"); end
      if (BIT_HALT >= REG_W)       begin : g_chk_halt  $error("halt bit outside register"); end
      if (ADDR_W < WDG_ADDR_W)     begin : g_chk_addr  $error("ADDR_W too small for register map"); end
      if (32'(INIT_DEFAULT) < MIN_INIT) begin : g_chk_init $error("INIT_DEFAULT is illegal"); end
   endgenerate

   wdg_wsel_t        wsel;
   logic [REG_W-1:0] ctrl_q, init_q;
   logic             noreboot_q;
   logic             halt, tick, expire, init_legal;
   logic [CNT_W-1:0] cnt;
   logic             tmo, second, boot;

   // write decode
   always_comb begin
      wsel        = '0;
      wsel.reload = reg_we_i && (reg_addr_i == ADDR_W'(OFS_RELOAD));
      wsel.stat1  = reg_we_i && (reg_addr_i == ADDR_W'(OFS_STAT1));
      wsel.stat2  = reg_we_i && (reg_addr_i == ADDR_W'(OFS_STAT2));
      wsel.ctrl   = reg_we_i && (reg_addr_i == ADDR_W'(OFS_CTRL));
      wsel.cfg    = reg_we_i && (reg_addr_i == ADDR_W'(OFS_CFG));
      wsel.init   = reg_we_i && (reg_addr_i == ADDR_W'(OFS_INIT));
   end

   assign init_legal = 32'(reg_wdata_i[CNT_W-1:0]) >= MIN_INIT;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         ctrl_q     <= CTRL_RST;
         init_q     <= INIT_RST;
         noreboot_q <= 1'b1;
      end else begin
         if (wsel.ctrl)                ctrl_q     <= reg_wdata_i;
         if (wsel.init && init_legal)  init_q     <= reg_wdata_i;
         if (wsel.cfg)                 noreboot_q <= reg_wdata_i[BIT_NOREBOOT];
      end
   end

   assign halt = ctrl_q[BIT_HALT];

   wdg_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .halt_i (halt),
      .tick_o (tick)
   );

   wdg_countdown #(.CNT_W(CNT_W), .INIT_DEFAULT(INIT_DEFAULT)) u_count (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick),
      .halt_i   (halt),
      .reload_i (wsel.reload),
      .init_i   (init_q[CNT_W-1:0]),
      .cnt_o    (cnt),
      .expire_o (expire)
   );

   wdg_escalate u_esc (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .expire_i     (expire),
      .noreboot_i   (noreboot_q),
      .clr_tmo_i    (wsel.stat1 && reg_wdata_i[BIT_TMO]),
      .clr_second_i (wsel.stat2 && reg_wdata_i[BIT_SECOND]),
      .clr_boot_i   (wsel.stat2 && reg_wdata_i[BIT_BOOT]),
      .tmo_o        (tmo),
      .second_o     (second),
      .boot_o       (boot),
      .evt_o        (expire_evt_o),
      .rst_req_o    (reset_req_o)
   );

   // read mux
   always_comb begin
      reg_rdata_o = '0;
      unique case (reg_addr_i)
         ADDR_W'(OFS_RELOAD): reg_rdata_o[CNT_W-1:0]    = cnt;
         ADDR_W'(OFS_STAT1):  reg_rdata_o[BIT_TMO]      = tmo;
         ADDR_W'(OFS_STAT2): begin
                              reg_rdata_o[BIT_SECOND]   = second;
                              reg_rdata_o[BIT_BOOT]     = boot;
         end
         ADDR_W'(OFS_CTRL):   reg_rdata_o               = ctrl_q;
         ADDR_W'(OFS_CFG):    reg_rdata_o[BIT_NOREBOOT] = noreboot_q;
         ADDR_W'(OFS_INIT):   reg_rdata_o               = init_q;
         default:             reg_rdata_o               = '0;
      endcase
   end

   AST_ILLEGAL_INIT_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wsel.init && !init_legal |=> $stable(init_q)); // R3
   AST_RELOAD_FORCES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wsel.reload |=> (cnt == $past(init_q[CNT_W-1:0]))); // R4
endmodule

// File: tb/wdg_two_stage_tb_top.sv
`timescale 1ns/1ps
module wdg_two_stage_tb_top;
   localparam int unsigned DIV = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        we = 1'b0;
   logic [4:0]  addr = '0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic        evt, rreq;

   int n_total = 0;
   int n_fail  = 0;
   int edges   = 0;
   bit done    = 0;

   always #2 clk = ~clk;
   always @(posedge clk) edges <= edges + 1;

   wdg_two_stage #(.TICK_DIV(DIV)) dut_i (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .reg_we_i     (we),
      .reg_addr_i   (addr),
      .reg_wdata_i  (wdata),
      .reg_rdata_o  (rdata),
      .expire_evt_o (evt),
      .reset_req_o  (rreq)
   );

   localparam logic [4:0] A_RLD = 5'h00, A_ST1 = 5'h04, A_ST2 = 5'h06,
                          A_CTL = 5'h08, A_CFG = 5'h0C, A_INI = 5'h12;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_total++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [15:0] d);
      @(negedge clk);
      we = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [15:0] d);
      addr = a;
      #1;
      d = rdata;
   endtask

   task automatic expect_reg(input logic [4:0] a, input logic [15:0] exp, input string req);
      logic [15:0] v;
      rd(a, v);
      check(v == exp, req, v, exp);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_reset_state();
      expect_reg(A_RLD, 16'h0032, "R1 count");
      expect_reg(A_ST1, 16'h0000, "R1 stat1");
      expect_reg(A_ST2, 16'h0000, "R1 stat2");
      expect_reg(A_CTL, 16'h0800, "R1 ctrl");
      expect_reg(A_CFG, 16'h0002, "R1 cfg");
      expect_reg(A_INI, 16'h0032, "R1 init");
      check(evt == 1'b0, "R1 evt", evt, 0);
      check(rreq == 1'b0, "R1 reset_req", rreq, 0);
   endtask

   task automatic t_init_reg();
      wr(A_INI, 16'hFC05);  expect_reg(A_INI, 16'hFC05, "R2 legal write");
      wr(A_INI, 16'h0403);  expect_reg(A_INI, 16'hFC05, "R3 value 3 ignored");
      wr(A_INI, 16'h0000);  expect_reg(A_INI, 16'hFC05, "R3 value 0 ignored");
      wr(A_INI, 16'h0004);  expect_reg(A_INI, 16'h0004, "R2 minimum legal");
      wr(A_INI, 16'hA805);  expect_reg(A_INI, 16'hA805, "R2 upper bits kept");
      expect_reg(A_RLD, 16'h0032, "R4 init write no reload");
      wr(A_RLD, 16'h1234);  expect_reg(A_RLD, 16'h0005, "R4 reload write");
   endtask

   task automatic t_halted();
      repeat (40) @(negedge clk);
      expect_reg(A_RLD, 16'h0005, "R5 halted count frozen");
      wr(A_CTL, 16'h0801);  expect_reg(A_CTL, 16'h0801, "R5 ctrl readback");
      wr(A_CTL, 16'h0800);
   endtask

   task automatic t_escalate_gated();
      int e0, guard;
      bit evt_seen;
      logic [15:0] v;
      wr(A_CTL, 16'h0000);
      e0 = edges;
      guard = 0;
      while (!evt && guard < 200) begin @(negedge clk); guard++; end
      check((edges - e0) == 4*6, "R6 first expiry time", edges - e0, 24);
      expect_reg(A_ST1, 16'h0008, "R7 timeout flag");
      @(negedge clk);
      check(evt == 1'b0, "R7 one-clock pulse", evt, 0);
      expect_reg(A_RLD, 16'h0005, "R6 reload on expiry");
      evt_seen = 0; guard = 0;
      rd(A_ST2, v);
      while (!v[1] && guard < 200) begin
         @(negedge clk); guard++;
         if (evt) evt_seen = 1;
         rd(A_ST2, v);
      end
      check((edges - e0) == 8*6, "R8 second expiry time", edges - e0, 48);
      check(!evt_seen, "R8 no event on second stage", evt_seen, 0);
      check(rreq == 1'b0, "R9 no-reboot blocks request", rreq, 0);
      expect_reg(A_ST2, 16'h0002, "R8 second flag only");
      guard = 0;
      rd(A_ST2, v);
      while (!v[2] && guard < 200) begin @(negedge clk); guard++; rd(A_ST2, v); end
      check((edges - e0) == 12*6, "R10 boot flag time", edges - e0, 72);
      expect_reg(A_ST2, 16'h0006, "R10 boot flag");
      wr(A_CTL, 16'h0800);
   endtask

   task automatic t_w1c();
      wr(A_ST2, 16'h0000);  expect_reg(A_ST2, 16'h0006, "R11 zero write keeps");
      wr(A_ST2, 16'h0004);  expect_reg(A_ST2, 16'h0002, "R11 clear boot");
      wr(A_ST2, 16'h0002);  expect_reg(A_ST2, 16'h0000, "R11 clear second");
      wr(A_ST1, 16'hFFF7);  expect_reg(A_ST1, 16'h0008, "R11 other bits keep");
      wr(A_ST1, 16'h0008);  expect_reg(A_ST1, 16'h0000, "R11 clear timeout");
   endtask

   task automatic t_ping();
      bit evt_seen = 0;
      wr(A_RLD, 16'h0000);
      wr(A_CTL, 16'h0000);
      for (int i = 0; i < 30; i++) begin
         for (int k = 0; k < 10; k++) begin @(negedge clk); if (evt) evt_seen = 1; end
         wr(A_RLD, 16'h0001);
      end
      check(!evt_seen, "R4 pinging prevents expiry", evt_seen, 0);
      expect_reg(A_ST1, 16'h0000, "R4 no flag while pinged");
      wr(A_CTL, 16'h0800);
   endtask

   task automatic t_reset_request();
      int e0, guard;
      wr(A_CFG, 16'h0000);  expect_reg(A_CFG, 16'h0000, "R9 gate readback");
      wr(A_RLD, 16'h0000);
      wr(A_CTL, 16'h0000);
      e0 = edges; guard = 0;
      while (!rreq && guard < 300) begin @(negedge clk); guard++; end
      check(rreq == 1'b1, "R9 request raised", rreq, 1);
      check((edges - e0) == 8*6, "R9 request time", edges - e0, 48);
      wr(A_CTL, 16'h0800);
      wr(A_ST1, 16'h0008);
      wr(A_ST2, 16'h0006);
      wr(A_CFG, 16'h0002);
      repeat (5) @(negedge clk);
      check(rreq == 1'b1, "R9 request sticky", rreq, 1);
      do_reset();
      check(rreq == 1'b0, "R1 request cleared by reset", rreq, 0);
   endtask

   initial begin
      #(4 * 100000);
      if (!done) begin
         n_total++; n_fail++;
         $display("FAIL watchdog: actual 0x0 expected 0x1");
         $display("%0d/%0d checks passed", n_total - n_fail, n_total);
         $finish;
      end
   end

   initial begin
      do_reset();
      t_reset_state();
      t_init_reg();
      t_halted();
      t_escalate_gated();
      t_w1c();
      t_ping();
      t_reset_request();
      done = 1;
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
   end
endmodule